// File: doc/BRIEF.md
# Branch Condition and Next-PC Unit

This block owns the program counter of a simple 32-bit processor and decides, every cycle, where execution goes next. It decodes the opcode of the instruction now being executed. A conditional branch tests a 4-bit condition code against the stored carry, overflow, negative and zero flags. An indirect jump adds a signed offset to a register value, and it may also ask for a return address to be written to a register. Every other instruction moves on to the next word, 4 bytes later.

The flags and the register value come from outside: flag generation and the register file belong to other blocks. The unit reports the computed next PC and whether control flow was redirected. On a jump-and-link it also gives the write request, the destination register and the return address. A halt input freezes the PC and blocks every redirect and every link write.

Top module: `branch_npc`

## Requirements
- R1: While `rst_n` is low, `pc` is forced to the parameter `RESET_PC` (default 0).
- R2: When `halt` is low and the opcode in `instr[31:27]` is neither 0x08 nor 0x09, `next_pc` is `pc + 4`, `taken` is 0 and `link_we` is 0.
- R3: Opcode 0x08 is a branch. Its condition code is `instr[26:23]`. Code 0000 is always taken. Codes 1000, 0111 and 1111 are never taken.
- R4: Branch codes 0001 and 1001 are taken on C clear and on C set. Codes 0010 and 1010 are taken on V clear and on V set. Code 0011 is taken on Z set and code 1011 on Z clear.
- R5: Branch code 0100 is taken when N equals V, and code 1100 when N differs from V. Code 0101 is taken when Z is clear and N equals V. Code 1101 is taken when Z is set or N differs from V.
- R6: Branch code 0110 is taken when N is clear and code 1110 when N is set.
- R7: A taken branch sets `next_pc` to `pc + 4` plus `instr[22:0]` sign-extended. A branch that is not taken gives `pc + 4` with `taken` low.
- R8: Opcode 0x09 is a jump and is always taken. `next_pc` is `rs1_val` plus `instr[15:0]` sign-extended. When `instr[16]` is 0, `link_we` stays low.
- R9: A jump with `instr[16]` = 1 raises `link_we`, with `link_rd` = `instr[26:22]` and `link_addr` = `pc + 4`.
- R10: While `halt` is high, `next_pc` equals `pc`, `taken` and `link_we` are 0, and `pc` does not change at the clock edge.
- R11: When out of reset, `pc` takes the value of `next_pc` at each rising clock edge.
- R12: `rs1_sel` always presents `instr[21:17]` as the register index for the jump base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| halt | input | 1 | Freezes the PC and blocks redirects and link writes |
| instr | input | 32 | Instruction being executed |
| flag_c | input | 1 | Stored carry flag |
| flag_v | input | 1 | Stored overflow flag |
| flag_n | input | 1 | Stored negative flag |
| flag_z | input | 1 | Stored zero flag |
| rs1_val | input | 32 | Value of the jump base register |
| rs1_sel | output | 5 | Index of the jump base register |
| pc | output | 32 | Current program counter |
| next_pc | output | 32 | Program counter for the next cycle |
| taken | output | 1 | Control flow is redirected this cycle |
| link_we | output | 1 | Return-address write request |
| link_rd | output | 5 | Destination register for the return address |
| link_addr | output | 32 | Return address (`pc + 4`) |

## Verification
`next_pc`, `taken`, `rs1_sel` and the three link outputs are combinational, so they are due in the same cycle as the instruction and flags that produce them. The bench samples them 2 ns after it drives the inputs on the falling edge, well before the next rising edge. The `pc` register is due one rising edge later. The driver queues that expected value, and a monitor pops it 1 ns after the edge and compares it with `pc`. One queued item matches one edge, so a halted cycle or an extra step cannot let a wrong value through.

// File: rtl/branch_npc.sv
module branch_npc #(
  parameter int          PC_W     = 32,
  parameter logic [31:0] RESET_PC = 32'h0,
  parameter logic [4:0]  OP_BR    = 5'h08,
  parameter logic [4:0]  OP_JMP   = 5'h09
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            halt,
  input  logic [31:0]     instr,
  input  logic            flag_c,
  input  logic            flag_v,
  input  logic            flag_n,
  input  logic            flag_z,
  input  logic [PC_W-1:0] rs1_val,
  output logic [4:0]      rs1_sel,
  output logic [PC_W-1:0] pc,
  output logic [PC_W-1:0] next_pc,
  output logic            taken,
  output logic            link_we,
  output logic [4:0]      link_rd,
  output logic [PC_W-1:0] link_addr
);

  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  logic [4:0]      opcode;
  logic            is_br, is_jmp;
  logic [2:0]      test_sel;
  logic            invert;
  logic            raw_hit, cond_hit;
  logic            ge;
  logic [PC_W-1:0] seq_pc, br_target, jmp_target;

  assign opcode   = instr[31:27];
  assign is_br    = (opcode == OP_BR);
  assign is_jmp   = (opcode == OP_JMP);
  assign test_sel = instr[25:23];
  assign invert   = instr[26];
  assign ge       = (flag_n == flag_v);

  always_comb begin
    case (test_sel)
      3'd0:    raw_hit = 1'b1;
      3'd1:    raw_hit = ~flag_c;
      3'd2:    raw_hit = ~flag_v;
      3'd3:    raw_hit = flag_z;
      3'd4:    raw_hit = ge;
      3'd5:    raw_hit = ~flag_z & ge;
      3'd6:    raw_hit = ~flag_n;
      default: raw_hit = 1'b0;
    endcase
  end

  assign cond_hit = (test_sel == 3'd7) ? 1'b0 : (raw_hit ^ invert);

  assign seq_pc     = pc + STEP;
  assign br_target  = seq_pc + {{(PC_W-23){instr[22]}}, instr[22:0]};
  assign jmp_target = rs1_val + {{(PC_W-16){instr[15]}}, instr[15:0]};

  assign taken = ~halt & (is_jmp | (is_br & cond_hit));

  always_comb begin
    if (halt)                 next_pc = pc;
    else if (is_jmp)          next_pc = jmp_target;
    else if (is_br && cond_hit) next_pc = br_target;
    else                      next_pc = seq_pc;
  end

  assign rs1_sel   = instr[21:17];
  assign link_we   = ~halt & is_jmp & instr[16];
  assign link_rd   = instr[26:22];
  assign link_addr = seq_pc;

  always_ff @(posedge clk) begin
    if (!rst_n) pc <= RESET_PC[PC_W-1:0];
    else        pc <= next_pc;
  end

  a_r1_reset_pc: assert property (@(posedge clk)
    !rst_n |=> pc == RESET_PC[PC_W-1:0]);

  a_r10_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> pc == $past(pc));

  a_r10_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> (!taken && !link_we && next_pc == pc));

  a_r2_sequential: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && instr[31:27] != OP_BR && instr[31:27] != OP_JMP) |=> pc == $past(pc) + STEP);

  a_r3_unused_codes_never: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[31:27] == OP_BR && (instr[25:23] == 3'b111 || instr[26:23] == 4'b1000)) |-> !taken);

  a_r5_ge_lt: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && instr[31:27] == OP_BR && instr[25:23] == 3'b100) |-> taken == ((flag_n ^ flag_v) == instr[26]));

  a_r8_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && instr[31:27] == OP_JMP) |=> pc == $past(rs1_val) + {{(PC_W-16){$past(instr[15])}}, $past(instr[15:0])});

  a_r9_link_needs_jump: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (taken && instr[31:27] == OP_JMP && link_addr == pc + STEP));

endmodule

// File: tb/test_branch_npc.sv
module test_branch_npc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        halt = 1'b0;
  logic [31:0] instr = 32'h0;
  logic        flag_c = 1'b0, flag_v = 1'b0, flag_n = 1'b0, flag_z = 1'b0;
  logic [31:0] rs1_val = 32'h0;
  logic [4:0]  rs1_sel;
  logic [31:0] pc, next_pc, link_addr;
  logic        taken, link_we;
  logic [4:0]  link_rd;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  logic [31:0] mpc;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  branch_npc i_branch_npc (
    .clk(clk), .rst_n(rst_n), .halt(halt), .instr(instr),
    .flag_c(flag_c), .flag_v(flag_v), .flag_n(flag_n), .flag_z(flag_z),
    .rs1_val(rs1_val), .rs1_sel(rs1_sel), .pc(pc), .next_pc(next_pc),
    .taken(taken), .link_we(link_we), .link_rd(link_rd), .link_addr(link_addr)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic bit cond_ok(input logic [3:0] code, input bit c, input bit v, input bit n, input bit z);
    case (code)
      4'b0000: return 1'b1;
      4'b1000: return 1'b0;
      4'b0001: return !c;
      4'b1001: return c;
      4'b0010: return !v;
      4'b1010: return v;
      4'b0011: return z;
      4'b1011: return !z;
      4'b0100: return n == v;
      4'b1100: return n != v;
      4'b0101: return !z && (n == v);
      4'b1101: return z || (n != v);
      4'b0110: return !n;
      4'b1110: return n;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string code_tag(input logic [3:0] code);
    case (code[2:0])
      3'd0, 3'd7:       return "R3";
      3'd1, 3'd2, 3'd3: return "R4";
      3'd4, 3'd5:       return "R5";
      default:          return "R6";
    endcase
  endfunction

  // driver: called on a falling edge, leaves on the next falling edge
  task automatic step(input logic [31:0] ins, input logic [3:0] flg, input logic [31:0] rv, input bit hlt, input string tag);
    logic [31:0] e_next;
    bit e_tk, e_lwe;
    logic [4:0] op;
    instr = ins; {flag_c, flag_v, flag_n, flag_z} = flg; rs1_val = rv; halt = hlt;
    op = ins[31:27];
    e_tk = 0; e_lwe = 0; e_next = mpc + 32'd4;
    if (hlt) e_next = mpc;
    else if (op == 5'h08) begin
      e_tk = cond_ok(ins[26:23], flg[3], flg[2], flg[1], flg[0]);
      if (e_tk) e_next = mpc + 32'd4 + {{9{ins[22]}}, ins[22:0]};
    end else if (op == 5'h09) begin
      e_tk = 1; e_lwe = ins[16];
      e_next = rv + {{16{ins[15]}}, ins[15:0]};
    end
    #2;
    check(tag, "next_pc", next_pc, e_next);
    check(tag, "taken", {31'b0, taken}, {31'b0, e_tk});
    check(tag, "link_we", {31'b0, link_we}, {31'b0, e_lwe});
    check("R12", "rs1_sel", {27'b0, rs1_sel}, {27'b0, ins[21:17]});
    if (e_lwe) begin
      check("R9", "link_rd", {27'b0, link_rd}, {27'b0, ins[26:22]});
      check("R9", "link_addr", link_addr, mpc + 32'd4);
    end
    exp_q.push_back(e_next);
    tag_q.push_back(tag);
    mpc = e_next;
    @(negedge clk);
  endtask

  // monitor: compares the registered PC after each rising edge (R11)
  always @(posedge clk) begin
    #1;
    if (rst_n && exp_q.size() > 0) begin
      string t;
      t = tag_q.pop_front();
      check({t, "/R11"}, "pc", pc, exp_q.pop_front());
    end
  end

  function automatic logic [31:0] br(input logic [3:0] code, input logic [22:0] d);
    return {5'h08, code, d};
  endfunction

  function automatic logic [31:0] jp(input logic [4:0] rd, input logic [4:0] rs, input bit lnk, input logic [15:0] imm);
    return {5'h09, rd, rs, lnk, imm};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset pc", pc, 32'h0);
    mpc = 32'h0;
    rst_n = 1'b1;

    step(32'h0, 4'h0, 32'h0, 0, "R2");
    step({5'h01, 27'h12345}, 4'hF, 32'h0, 0, "R2");
    step({5'h07, 27'h7FFFFFF}, 4'h5, 32'h0, 0, "R2");
    step({5'h0A, 27'h0000FF}, 4'hA, 32'h0, 0, "R2");

    for (int code = 0; code < 16; code++)
      for (int f = 0; f < 16; f++)
        step(br(code[3:0], (f[0] ? 23'h7FFFF0 : 23'h000024)), f[3:0], 32'h0, 0, code_tag(code[3:0]));

    step(br(4'b0000, 23'h3FFFFF), 4'h0, 32'h0, 0, "R7");
    step(br(4'b0000, 23'h400000), 4'h0, 32'h0, 0, "R7");
    step(br(4'b1000, 23'h400000), 4'h0, 32'h0, 0, "R7");

    step(jp(5'd3, 5'd9, 0, 16'hFFF0), 4'h0, 32'h0000_1000, 0, "R8");
    step(jp(5'd0, 5'd1, 0, 16'h7FFF), 4'hF, 32'hFFFF_FF00, 0, "R8");
    step(jp(5'd17, 5'd2, 1, 16'h0040), 4'h0, 32'h0002_0000, 0, "R9");
    step(jp(5'd31, 5'd30, 1, 16'h8000), 4'h3, 32'h1234_5678, 0, "R9");

    step(br(4'b0000, 23'h000100), 4'h0, 32'h0, 1, "R10");
    step(jp(5'd5, 5'd6, 1, 16'h0010), 4'h0, 32'hAAAA_0000, 1, "R10");
    step(32'h0, 4'h0, 32'h0, 1, "R10");
    step(32'h0, 4'h0, 32'h0, 0, "R2");

    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1", "pc after second reset", pc, 32'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule